// File: doc/BRIEF.md
# Multicycle Processor Datapath with Time-Shared ALU and Memory

This block is the datapath half of a 32-bit processor that spends several clock cycles on each instruction. One word-addressed memory holds both code and data. One ALU does every calculation: PC increments, branch targets, effective addresses and register arithmetic. An instruction register keeps the current instruction steady while it runs. A branch-target register keeps an address worked out early in the instruction. A 32-entry register file, with entry 0 fixed at zero, holds the operands.

An external sequencer drives the block with one control word per cycle: operand selects, ALU mode, immediate extension, load enables and write enables. The block sends back the opcode, the function field and the ALU zero flag so the sequencer can decode and branch. The PC and the ALU result are also brought out so the surrounding logic can observe them.

Writes follow a settle-then-enable discipline. The control that forms a write address and its data is applied for one cycle first. The write enable is raised only in the next cycle, with the same selects held.

Top module: `mc_datapath`

## Requirements
- R1: After a synchronous active-low reset, the PC is 0 and the instruction register is 0, so the opcode and function outputs read 0.
- R2: With ir_we=1, pc_we=1, PC as operand A, the constant 4 as operand B and ALU mode Add (00), one clock edge loads the instruction register from the memory word at PC[AW+1:2] and advances the PC by 4. The opcode output is bits [31:26] of the instruction and the function output is bits [5:0].
- R3: While ir_we=0, the opcode and function outputs keep their values, even when the PC moves.
- R4: The immediate is instruction bits [15:0]. b_sel=11 feeds it to operand B, sign-extended when sign_ext=1 and zero-extended when sign_ext=0.
- R5: b_sel=10 feeds operand B with the sign-extended immediate shifted left by 2. b_sel=01 feeds register port B (index in bits [20:16]). b_sel=00 feeds the constant 4. a_from_reg=1 replaces the PC with register port A (index in bits [25:21]).
- R6: ALU modes are 00 Add, 01 Sub and 10 Or. Mode 11 takes its operation from the function field: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A signed set-less-than. The zero output is 1 exactly when the ALU result is 0.
- R7: A register write goes to index bits [15:11] when dst_rd=1 and to bits [20:16] when dst_rd=0. It writes the ALU result when wb_from_mem=0 and the memory read data when wb_from_mem=1.
- R8: Register 0 reads as zero, even after a write to it.
- R9: The target register captures the ALU result on an edge with tgt_we=1 and keeps it otherwise.
- R10: The PC loads on an edge when pc_we=1, or when pc_we_cond=1 and zero=1. Otherwise it holds. The value loaded is the ALU result when pc_from_tgt=0 and the target register when pc_from_tgt=1.
- R11: With mem_we=1, register port B is written to the memory word addressed by ALU result bits [AW+1:2]. With addr_from_alu=1, the read port is addressed by the ALU result instead of the PC.
- R12: A memory write and an instruction fetch at a different word can happen on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_we | input | 1 | Load PC unconditionally |
| pc_we_cond | input | 1 | Load PC when zero is 1 |
| pc_from_tgt | input | 1 | PC source: 0 ALU result, 1 target register |
| tgt_we | input | 1 | Capture ALU result in target register |
| addr_from_alu | input | 1 | Memory read address: 0 PC, 1 ALU result |
| mem_we | input | 1 | Memory write enable |
| ir_we | input | 1 | Instruction register load enable |
| dst_rd | input | 1 | Register write index: 0 bits [20:16], 1 bits [15:11] |
| rf_we | input | 1 | Register file write enable |
| a_from_reg | input | 1 | Operand A: 0 PC, 1 register port A |
| b_sel | input | 2 | Operand B select |
| alu_mode | input | 2 | ALU mode |
| sign_ext | input | 1 | Immediate extension: 1 sign, 0 zero |
| wb_from_mem | input | 1 | Register write data: 0 ALU, 1 memory |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| zero | output | 1 | ALU result is zero |
| pc_out | output | 32 | Current PC |
| alu_out | output | 32 | Current ALU result |

## Verification
The write-timing assertions rely on the sequencer. Whenever mem_we or rf_we is high, the address and data feeding that write must hold the same values they had one edge earlier. The PC and target assertions need nothing from the inputs beyond reset. The stimulus meets the write condition in every instruction: it spends one cycle forming the address or result with the write enable low, then repeats the same selects with the enable raised. The cycles before a write already carry the final write index and write-back source, so those values do not change at the edge where the write happens.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int MEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pc_we,
  input  logic        pc_we_cond,
  input  logic        pc_from_tgt,
  input  logic        tgt_we,
  input  logic        addr_from_alu,
  input  logic        mem_we,
  input  logic        ir_we,
  input  logic        dst_rd,
  input  logic        rf_we,
  input  logic        a_from_reg,
  input  logic [1:0]  b_sel,
  input  logic [1:0]  alu_mode,
  input  logic        sign_ext,
  input  logic        wb_from_mem,
  output logic [5:0]  opcode,
  output logic [5:0]  funct,
  output logic        zero,
  output logic [31:0] pc_out,
  output logic [31:0] alu_out
);
  localparam int AW = $clog2(MEM_WORDS);
  localparam logic [1:0] M_ADD = 2'b00, M_SUB = 2'b01, M_OR = 2'b10, M_FN = 2'b11;
  localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_AND = 6'h24, F_OR = 6'h25, F_SLT = 6'h2A;

  logic [31:0] pc_q, ir_q, tgt_q;
  logic [31:0] rf [32];
  logic [31:0] mem [MEM_WORDS];

  logic [4:0]  rs_i, rt_i, rd_i, wb_idx;
  logic [15:0] imm;
  logic [31:0] rd_a, rd_b, ext_imm, br_off, op_a, op_b, alu_y, mem_rdata, wb_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic pc_load;

  assign rs_i    = ir_q[25:21];
  assign rt_i    = ir_q[20:16];
  assign rd_i    = ir_q[15:11];
  assign imm     = ir_q[15:0];
  assign opcode  = ir_q[31:26];
  assign funct   = ir_q[5:0];

  assign rd_a    = rf[rs_i];
  assign rd_b    = rf[rt_i];
  assign ext_imm = sign_ext ? {{16{imm[15]}}, imm} : {16'b0, imm};
  assign br_off  = {{14{imm[15]}}, imm, 2'b00};
  assign op_a    = a_from_reg ? rd_a : pc_q;

  always_comb begin
    case (b_sel)
      2'b00:   op_b = 32'd4;
      2'b01:   op_b = rd_b;
      2'b10:   op_b = br_off;
      default: op_b = ext_imm;
    endcase
  end

  always_comb begin
    case (alu_mode)
      M_ADD: alu_y = op_a + op_b;
      M_SUB: alu_y = op_a - op_b;
      M_OR:  alu_y = op_a | op_b;
      default: begin
        case (funct)
          F_SUB:   alu_y = op_a - op_b;
          F_AND:   alu_y = op_a & op_b;
          F_OR:    alu_y = op_a | op_b;
          F_SLT:   alu_y = {31'b0, $signed(op_a) < $signed(op_b)};
          F_ADD:   alu_y = op_a + op_b;
          default: alu_y = op_a + op_b;
        endcase
      end
    endcase
  end

  assign zero    = (alu_y == 32'b0);
  assign alu_out = alu_y;
  assign pc_out  = pc_q;

  assign rd_addr   = addr_from_alu ? alu_y[AW+1:2] : pc_q[AW+1:2];
  assign wr_addr   = alu_y[AW+1:2];
  assign mem_rdata = mem[rd_addr];

  assign wb_idx  = dst_rd ? rd_i : rt_i;
  assign wb_data = wb_from_mem ? mem_rdata : alu_y;
  assign pc_load = pc_we | (pc_we_cond & zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      tgt_q <= '0;
    end else begin
      if (pc_load) pc_q  <= pc_from_tgt ? tgt_q : alu_y;
      if (ir_we)   ir_q  <= mem_rdata;
      if (tgt_we)  tgt_q <= alu_y;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (rf_we && wb_idx != 5'd0) begin
      rf[wb_idx] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_addr] <= rd_b;
  end

  a_r8_r0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rf[0] == 32'b0);

  a_r9_tgt_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(tgt_we) |-> tgt_q == $past(alu_y));

  a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(pc_we) && !($past(pc_we_cond) && $past(zero)) |-> $stable(pc_q));

  a_r11_mem_write_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && mem_we |-> $stable(alu_y) && $stable(rd_b));

  a_r7_rf_write_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && rf_we |-> $stable(wb_idx) && $stable(wb_data));
endmodule

// File: tb/mc_datapath_bench.sv
`timescale 1ns/1ps
module mc_datapath_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, pc_we, pc_we_cond, pc_from_tgt, tgt_we, addr_from_alu, mem_we, ir_we;
  logic dst_rd, rf_we, a_from_reg, sign_ext, wb_from_mem;
  logic [1:0] b_sel, alu_mode;
  logic [5:0] opcode, funct;
  logic zero;
  logic [31:0] pc_out, alu_out;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [31:0] prog [16];

  mc_datapath u_mc_datapath (
    .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
    .pc_from_tgt(pc_from_tgt), .tgt_we(tgt_we), .addr_from_alu(addr_from_alu),
    .mem_we(mem_we), .ir_we(ir_we), .dst_rd(dst_rd), .rf_we(rf_we),
    .a_from_reg(a_from_reg), .b_sel(b_sel), .alu_mode(alu_mode),
    .sign_ext(sign_ext), .wb_from_mem(wb_from_mem), .opcode(opcode),
    .funct(funct), .zero(zero), .pc_out(pc_out), .alu_out(alu_out)
  );

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] im);
    return {op, rs, rt, im};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    pc_we = 0; pc_we_cond = 0; pc_from_tgt = 0; tgt_we = 0; addr_from_alu = 0;
    mem_we = 0; ir_we = 0; dst_rd = 0; rf_we = 0; a_from_reg = 0;
    b_sel = 2'b00; alu_mode = 2'b00; sign_ext = 0; wb_from_mem = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 pc", pc_out, 32'h0);
    chk("R1 opcode", {26'b0, opcode}, 32'h0);
    chk("R1 funct", {26'b0, funct}, 32'h0);
  endtask

  task automatic t_fetch(input int idx, input logic [31:0] exp_pc);
    clr(); ir_we = 1; pc_we = 1;
    cyc(); clr();
    chk("R2 opcode", {26'b0, opcode}, {26'b0, prog[idx][31:26]});
    chk("R2 funct", {26'b0, funct}, {26'b0, prog[idx][5:0]});
    chk("R2 pc", pc_out, exp_pc);
  endtask

  task automatic t_ori(input logic [31:0] sext_exp, input logic [31:0] or_exp);
    clr(); a_from_reg = 1; b_sel = 2'b11; sign_ext = 1; #1;
    chk("R4 sign-extended immediate", alu_out, sext_exp);
    cyc(); alu_mode = 2'b10; sign_ext = 0; #1;
    chk("R4 zero-extended or", alu_out, or_exp);
    cyc(); rf_we = 1;
    cyc(); clr();
  endtask

  task automatic t_rtype(input logic [31:0] exp, input logic exp_zero);
    clr(); a_from_reg = 1; b_sel = 2'b01; alu_mode = 2'b11; dst_rd = 1; #1;
    chk("R6 function result", alu_out, exp);
    chk("R6 zero flag", {31'b0, zero}, {31'b0, exp_zero});
    cyc(); rf_we = 1;
    cyc(); clr();
  endtask

  task automatic t_store();
    clr(); a_from_reg = 1; b_sel = 2'b11; sign_ext = 1; #1;
    chk("R11 effective address", alu_out, 32'h0000_00F0);
    cyc(); mem_we = 1; ir_we = 1;
    cyc(); clr();
    chk("R12 fetch alongside store", {26'b0, opcode}, 32'h23);
    pc_we = 1;
    cyc(); clr();
    chk("R12 pc after advance", pc_out, 32'h24);
  endtask

  task automatic t_load();
    clr(); a_from_reg = 1; b_sel = 2'b11; sign_ext = 1; addr_from_alu = 1; wb_from_mem = 1;
    cyc(); rf_we = 1;
    cyc(); clr();
  endtask

  task automatic t_branch(input logic [31:0] tgt_exp, input logic exp_zero, input logic [31:0] exp_pc);
    clr(); b_sel = 2'b10; tgt_we = 1; #1;
    chk("R5 shifted branch offset", alu_out, tgt_exp);
    cyc(); clr();
    a_from_reg = 1; b_sel = 2'b01; alu_mode = 2'b01; pc_we_cond = 1; pc_from_tgt = 1; #1;
    chk("R10 compare zero", {31'b0, zero}, {31'b0, exp_zero});
    cyc(); clr();
    chk("R10 conditional pc", pc_out, exp_pc);
  endtask

  task automatic t_hold();
    clr(); pc_we = 1;
    cyc(); cyc(); clr();
    chk("R3 opcode held", {26'b0, opcode}, 32'h0);
    chk("R3 funct held", {26'b0, funct}, 32'h25);
    chk("R3 pc moved", pc_out, 32'h48);
    pc_we = 1; pc_from_tgt = 1;
    cyc(); clr();
    chk("R9 target kept", pc_out, 32'h4C);
  endtask

  initial begin
    prog[0]  = enc_i(6'h0D, 5'd0, 5'd1, 16'h1234);
    prog[1]  = enc_i(6'h0D, 5'd0, 5'd2, 16'h8001);
    prog[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
    prog[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'h22);
    prog[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'h24);
    prog[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'h25);
    prog[6]  = enc_r(5'd1, 5'd2, 5'd7, 6'h2A);
    prog[7]  = enc_i(6'h2B, 5'd0, 5'd3, 16'h00F0);
    prog[8]  = enc_i(6'h23, 5'd0, 5'd8, 16'h00F0);
    prog[9]  = enc_i(6'h04, 5'd8, 5'd3, 16'h0003);
    prog[10] = 32'h0;
    prog[11] = 32'h0;
    prog[12] = 32'h0;
    prog[13] = enc_i(6'h04, 5'd1, 5'd2, 16'h0005);
    prog[14] = enc_i(6'h0D, 5'd0, 5'd0, 16'h5555);
    prog[15] = enc_r(5'd0, 5'd7, 5'd9, 6'h25);
    for (int i = 0; i < 64; i++)
      u_mc_datapath.mem[i] <= (i < 16) ? prog[i] : 32'h0;

    clr(); rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1 t_reset();

    t_fetch(0, 32'h04);  t_ori(32'h0000_1234, 32'h0000_1234);
    t_fetch(1, 32'h08);  t_ori(32'hFFFF_8001, 32'h0000_8001);
    t_fetch(2, 32'h0C);  t_rtype(32'h0000_9235, 1'b0);
    t_fetch(3, 32'h10);  t_rtype(32'hFFFF_9233, 1'b0);
    t_fetch(4, 32'h14);  t_rtype(32'h0000_0000, 1'b1);
    t_fetch(5, 32'h18);  t_rtype(32'h0000_9235, 1'b0);
    t_fetch(6, 32'h1C);  t_rtype(32'h0000_0001, 1'b0);
    t_fetch(7, 32'h20);  t_store();
    t_load();
    t_fetch(9, 32'h28);  t_branch(32'h34, 1'b1, 32'h34);
    t_fetch(13, 32'h38); t_branch(32'h4C, 1'b0, 32'h38);
    t_fetch(14, 32'h3C); t_ori(32'h0000_5555, 32'h0000_5555);
    t_fetch(15, 32'h40); t_rtype(32'h0000_0001, 1'b0);
    t_hold();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule